// File: doc/BRIEF.md
# Address-Masked Bidirectional Port Data Register

This block holds the data and direction state of a small bidirectional pin port and lets software touch single pins without a read-modify-write. The port data register is visible through a window of word addresses. The address of each word carries its own bit mask, so one access reads or changes just the pins that are picked. A separate direction register chooses, pin by pin, whether the port drives the stored value or samples the outside world.

Pins that are inputs are passed through a synchronizer and copied into the data register on every cycle. Pins that are outputs drive the stored bit. An input pin presents a high level on its output. A bus access is a one-cycle request in the idle state. A response cycle follows it, and the read data is valid in that cycle. The access controller has two states. ACC_IDLE accepts a request (transition *accept*: ACC_IDLE to ACC_RESP when `bus_req` is high). ACC_RESP presents the response and always returns to idle (transition *complete*: ACC_RESP to ACC_IDLE). With no request, ACC_IDLE stays where it is (transition *wait*).

Top module: `masked_port`

## Requirements
- R1: After reset the direction register is 0, the data register is 0, every `pin_out` bit is 1, `bus_ready` is 1 and `bus_ack` is 0.
- R2: A read at a byte offset below 0x400 returns the data register ANDed with the mask taken from address bits [9:2]. Bit i of that field selects pin i.
- R3: A write at a byte offset below 0x400 changes data bit i only when address bit i+2 is 1 and direction bit i is 1. The direction is taken as it stood before that access. Every other data bit keeps its value.
- R4: The direction register is read and written at byte offset 0x400. Bit i set to 1 makes pin i an output.
- R5: `pin_out` bit i equals data bit i when pin i is an output and is 1 when pin i is an input.
- R6: For an input pin, `pin_in` passes through two synchronizer flops and then into the data register. A change in the cycle before rising edge e1 is still old for a read accepted at edge e3 and is new for a read accepted at edge e4.
- R7: A request is accepted only while `bus_ready` is 1. Exactly one `bus_ack` cycle follows on the next cycle, and `bus_ready` is 0 during that cycle. A request raised while `bus_ready` is 0 has no effect and yields no acknowledge.
- R8: Writes to any offset other than the data window and 0x400 change nothing. Reads from such offsets return 0. Writes acknowledge with `bus_rdata` 0.
- R9: Address bits [1:0] play no part in decoding. For example, 0x3FF reads the same as 0x3FC.
- R10: For an output pin the external `pin_in` level has no effect on the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, taken while bus_ready is high |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Controller is idle and accepts a request |
| bus_ack | output | 1 | Response cycle of an accepted access |
| bus_rdata | output | 8 | Read data, valid while bus_ack is high |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Levels driven towards the pins |

## Verification
Masked accesses are tried with full, single-bit, contiguous-field and scattered masks against several data patterns. This separates a design that ignores the address mask from one that applies it only on reads or only on writes. Writes under a partial direction setting show whether the direction gate is applied. Pin patterns that disagree with stored output bits show whether output pins wrongly sample. A read accepted at edge e3 and one accepted at edge e4 after a pin change pin down the synchronizer depth. Reserved offsets, offsets with nonzero low bits, and requests held during the response cycle show that decoding and the handshake ignore what they must.

// File: rtl/mport_pkg.sv
package mport_pkg;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/mport_sync.sv
module mport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/mport_decode.sv
module mport_decode
    import mport_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned PIN_W      = 8,
    parameter int unsigned DIR_OFFSET = 32'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PIN_W-1:0]  mask
);

    localparam int unsigned     WIN_LSB  = PIN_W + 2;
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);
    localparam logic [ADDR_W-3:0] DIR_WORD = DIR_ADDR[ADDR_W-1:2];

    logic       in_window;
    logic       is_dir;
    logic [1:0] unused_byte_lane;

    assign unused_byte_lane = addr[1:0];
    assign in_window        = (addr[ADDR_W-1:WIN_LSB] == '0);
    assign is_dir           = (addr[ADDR_W-1:2] == DIR_WORD);
    assign mask             = addr[WIN_LSB-1:2];

    always_comb begin
        if (in_window)   sel = SEL_DATA;
        else if (is_dir) sel = SEL_DIR;
        else             sel = SEL_NONE;
    end

endmodule

// File: rtl/mport_regs.sv
module mport_regs #(
    parameter int unsigned PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             dir_wr,
    input  logic [PIN_W-1:0] wr_mask,
    input  logic [PIN_W-1:0] wr_value,
    input  logic [PIN_W-1:0] pin_level,
    output logic [PIN_W-1:0] data_q,
    output logic [PIN_W-1:0] dir_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_wr) dir_q <= wr_value;
    end

    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_q[i] <= 1'b0;
                end else if (!dir_q[i]) begin
                    data_q[i] <= pin_level[i];
                end else if (data_wr && wr_mask[i]) begin
                    data_q[i] <= wr_value[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/masked_port.sv
module masked_port
    import mport_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned PIN_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIR_OFFSET  = 32'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out
);

    acc_state_e       state_q, state_d;
    reg_sel_e         acc_sel;
    logic [PIN_W-1:0] acc_mask;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] data_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] rdata_q;
    logic             accept;

    mport_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    mport_decode #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .DIR_OFFSET(DIR_OFFSET)) u_decode (
        .addr (bus_addr),
        .sel  (acc_sel),
        .mask (acc_mask)
    );

    assign accept = bus_req && (state_q == ACC_IDLE);

    mport_regs #(.PIN_W(PIN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (accept && bus_we && (acc_sel == SEL_DATA)),
        .dir_wr    (accept && bus_we && (acc_sel == SEL_DIR)),
        .wr_mask   (acc_mask),
        .wr_value  (bus_wdata),
        .pin_level (pin_sync),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // transitions: wait, accept, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (bus_req) state_d = ACC_RESP;
            ACC_RESP: state_d = ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_ready = (state_q == ACC_IDLE);
        bus_ack   = (state_q == ACC_RESP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            if (bus_we) begin
                rdata_q <= '0;
            end else begin
                unique case (acc_sel)
                    SEL_DATA: rdata_q <= data_q & acc_mask;
                    SEL_DIR:  rdata_q <= dir_q;
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = (data_q & dir_q) | ~dir_q;

endmodule

// File: rtl/masked_port_chk.sv
module masked_port_chk #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned PIN_W      = 8,
    parameter int unsigned DIR_OFFSET = 32'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              bus_ack,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  dir_q,
    input logic [PIN_W-1:0]  data_q
);

    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

    logic win;
    logic dir_hit;
    logic take;

    assign win     = (bus_addr[ADDR_W-1:PIN_W+2] == '0);
    assign dir_hit = (bus_addr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
    assign take    = bus_req && bus_ready;

    assert_accept_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> bus_ack);

    assert_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !bus_ready);

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_input_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        &(pin_out | dir_q));

    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && bus_we && win) |=> ((data_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    assert_read_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bus_we && win) |=> ((bus_rdata & ~$past(bus_addr[PIN_W+1:2])) == '0));

    assert_reserved_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_we && !win && !dir_hit) |=> $stable(dir_q));

endmodule

bind masked_port masked_port_chk #(
    .ADDR_W(ADDR_W), .PIN_W(PIN_W), .DIR_OFFSET(DIR_OFFSET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .dir_q     (dir_q),
    .data_q    (data_q)
);

// File: tb/tb_masked_port.sv
module tb_masked_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_ready;
    logic        bus_ack;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    logic [7:0] m_dir  = '0;
    logic [7:0] m_data = '0;

    always #10 clk = ~clk;

    masked_port dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: pops scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R7: unexpected ack, rdata %02h expected none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                check({7'd0, bus_ready}, 8'h00, "R7 ready low during ack");
            end
        end
    end

    function automatic logic [7:0] cur_data();
        return (m_dir & m_data) | (~m_dir & pin_in);
    endfunction

    function automatic logic [7:0] model_read(input logic [11:0] a);
        if (a < 12'h400)            return cur_data() & a[9:2];
        if (a[11:2] == 10'h100)     return m_dir;
        return 8'h00;
    endfunction

    task automatic access(input logic we, input logic [11:0] a, input logic [7:0] wd,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] wd, input string tag);
        if (a < 12'h400) begin
            m_data = (m_data & ~(a[9:2] & m_dir)) | (wd & a[9:2] & m_dir);
        end else if (a[11:2] == 10'h100) begin
            m_data = cur_data();
            m_dir  = wd;
        end
        access(1'b1, a, wd, 8'h00, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        access(1'b0, a, 8'h00, model_read(a), tag);
    endtask

    task automatic chk_pins(input string tag);
        check(pin_out, (m_dir & m_data) | ~m_dir, tag);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out, 8'hFF, "R1 pin_out after reset");
        check({7'd0, bus_ready}, 8'h01, "R1 ready after reset");
        check({7'd0, bus_ack}, 8'h00, "R1 ack after reset");
        rd(12'h3FC, "R1 data after reset");
        rd(12'h400, "R1 dir after reset");

        // direction and full-mask writes
        wr(12'h400, 8'hFF, "R4 write dir");
        rd(12'h400, "R4 read dir");
        chk_pins("R5 all outputs low");
        wr(12'h3FC, 8'hA5, "R3 full mask write");
        rd(12'h3FC, "R2 full mask read");
        chk_pins("R5 outputs A5");
        wr(12'h00C, 8'hFF, "R3 mask 03 write");
        wr(12'h200, 8'h00, "R3 mask 80 write");
        rd(12'h3FC, "R3 after partial writes");
        rd(12'h0F0, "R2 field mask 3C");
        rd(12'h148, "R2 scattered mask 52");
        rd(12'h000, "R2 empty mask");

        // direction gate
        wr(12'h400, 8'h0F, "R4 dir 0F");
        wr(12'h3FC, 8'hF0, "R3 gated by dir");
        chk_pins("R5 mixed direction");
        pin_in = 8'hC3; settle();
        rd(12'h3FC, "R10 mixed read with pins C3");
        chk_pins("R5 inputs high under pins");
        pin_in = 8'h3C; settle();
        rd(12'h3FC, "R10 output bits ignore pins 3C");

        // synchronizer latency, all inputs
        wr(12'h400, 8'h00, "R4 all inputs");
        settle();
        rd(12'h3FC, "R6 settled 3C");
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk);
        access(1'b0, 12'h3FC, 8'h00, 8'h3C, "R6 read at e3 still old");
        pin_in = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        access(1'b0, 12'h3FC, 8'h00, 8'hA5, "R6 read at e4 new");

        // reserved offsets
        wr(12'h400, 8'h33, "R4 dir 33");
        wr(12'h404, 8'hFF, "R8 write 404");
        wr(12'h800, 8'hFF, "R8 write 800");
        wr(12'hFFC, 8'h00, "R8 write FFC");
        rd(12'h400, "R8 dir unchanged");
        rd(12'h404, "R8 read 404");
        rd(12'hFD0, "R8 read FD0");
        chk_pins("R8 pins unchanged");

        // low address bits
        rd(12'h3FF, "R9 read 3FF");
        rd(12'h0F3, "R9 read 0F3");
        wr(12'h402, 8'hFF, "R9 dir via 402");
        rd(12'h401, "R9 dir via 401");

        // request while busy is ignored
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h400; bus_wdata = 8'h0F;
        exp_q.push_back(8'h00); tag_q.push_back("R7 accepted write");
        m_data = cur_data(); m_dir = 8'h0F;
        @(negedge clk);
        bus_wdata = 8'h55;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        rd(12'h400, "R7 busy request ignored");

        repeat (3) @(negedge clk);
        check(exp_q.size()[7:0], 8'h00, "R7 every request acknowledged");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule